// File: doc/BRIEF.md
# Quadrant-Tracked Audio Sample Ring

A circular store of audio samples that sits between a bursty producer, such as block reads returning from slow external memory, and a steady consumer that takes one sample per sample-rate tick. The storage is cut into four equal quadrants. Pointer spacing is judged by quadrant rather than by a raw fill count. The healthy state has the writer two quadrants ahead of the reader, which leaves a full quadrant of slack that absorbs fetch latency and jitter.

Each time the reader leaves a quadrant, the block emits a one-cycle refill request that names the quadrant just vacated. The fetch engine can then start a background burst into that region long before the reader comes back to it. Writes use a valid/ready handshake. A transfer takes place on a cycle where both `wr_valid` and `wr_ready` are high. The producer must hold `wr_data` steady while `wr_valid` is high and `wr_ready` is low. Each such stalled cycle is logged as an overrun. When the reader outruns the writer, the output repeats its last sample and flags an underrun.

A synchronous flush puts the read pointer at slot 0 and the write pointer two quadrants ahead. The two quadrants in between play out as silence, so a new sound starts after a fixed, bounded delay.

Top module: `quad_ring_buf`

## Requirements
- R1: After reset or flush the read pointer is at slot 0 and the write pointer is at slot 2·DEPTH/4. `spaced_ok` is 1 and `smp_out` is 0. The first 2·DEPTH/4 reads return 0, and after them the written samples follow.
- R2: `wr_ready` is 0 exactly when the slot the next write would fill lies in the quadrant being read (quadrant index = top two address bits) and at least DEPTH/4 samples are stored. A sample is accepted on a cycle with `wr_valid` and `wr_ready` both high.
- R3: Every cycle with `wr_valid`=1, `wr_ready`=0 and no flush gives an `overrun` pulse in the next cycle and adds one to `ovr_count`. `ovr_count` saturates and never decreases.
- R4: A `tick` while samples are stored puts the oldest sample on `smp_out` one cycle later. Samples come out in write order.
- R5: A `tick` while the store is empty gives an `underrun` pulse one cycle later, and `smp_out` keeps the last sample.
- R6: A read from the last slot of a quadrant gives a one-cycle `refill_req` pulse in the next cycle, with `refill_quad` set to that quadrant's index.
- R7: `spaced_ok` is 1 exactly when the write quadrant is two ahead of the read quadrant, modulo 4.
- R8: `flush` acts at the next clock edge. It holds `wr_ready` low, drops any offered write and any tick, clears `smp_out` to 0, and leaves `ovr_count` unchanged.
- R9: `smp_out` changes only in the cycle after a `tick` or a `flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restart pointers for a new sound |
| wr_valid | input | 1 | Producer offers a sample |
| wr_ready | output | 1 | Store accepts the offered sample |
| wr_data | input | DW | Sample being offered |
| tick | input | 1 | Sample-rate read strobe |
| smp_out | output | DW | Current output sample |
| underrun | output | 1 | Pulse: tick found the store empty |
| refill_req | output | 1 | Pulse: reader left a quadrant |
| refill_quad | output | 2 | Index of the quadrant just vacated |
| overrun | output | 1 | Pulse: an offered write was refused |
| ovr_count | output | CNT_W | Saturating count of refused offers |
| spaced_ok | output | 1 | Pointers sit in opposite quadrants |

## Verification
The first pattern is a long burst of writes with no reads. It fills the two quadrants ahead of the reader and then runs into the reader's quadrant, which separates correct refusal from plain overflow. Single reads then march the reader across quadrant edges, so each refill index can be matched against the crossing that caused it. A fine interleave of writes and reads keeps the writer hovering around the reader's quadrant and tests the acceptance rule at every offset. Draining to empty and flushing in the middle of a stream, with a write offered at the same edge, show the hold-last behaviour, the priority of flush and the silent lead-in.

// File: rtl/qring_pkg.sv
package qring_pkg;
  localparam int NUM_QUADS = 4;
  typedef logic [1:0] quad_t;
  localparam quad_t OPPOSITE = 2'd2;
endpackage

// File: rtl/qring_store.sv
module qring_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic          mute,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (re)       q <= mute ? '0 : mem[raddr];
  end
endmodule

// File: rtl/qring_ptrs.sv
module qring_ptrs
  import qring_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int QSZ  = DEPTH / NUM_QUADS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_valid,
  input  logic          tick,
  output logic          wr_ready,
  output logic          wr_go,
  output logic          rd_go,
  output logic          starve,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output quad_t         rq,
  output logic          last_in_quad,
  output logic          spaced_ok
);
  logic [AW:0] wp, rp, fill;
  quad_t       wq;
  logic        empty;

  assign fill  = wp - rp;
  assign empty = (fill == '0);
  assign wq    = wp[AW-1 -: 2];
  assign rq    = rp[AW-1 -: 2];
  assign waddr = wp[AW-1:0];
  assign raddr = rp[AW-1:0];

  assign wr_ready     = !flush && !((wq == rq) && (fill >= (AW+1)'(QSZ)));
  assign wr_go        = wr_valid && wr_ready;
  assign rd_go        = tick && !flush && !empty;
  assign starve       = tick && !flush && empty;
  assign last_in_quad = (rp[AW-3:0] == (AW-2)'(QSZ-1));
  assign spaced_ok    = (quad_t'(wq - rq) == OPPOSITE);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rp <= '0;
      wp <= (AW+1)'(2*QSZ);
    end else begin
      if (wr_go) wp <= wp + 1'b1;
      if (rd_go) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/qring_watch.sv
module qring_watch
  import qring_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rd_go,
  input  logic             starve,
  input  logic             last_in_quad,
  input  quad_t            rq,
  input  logic             refused,
  output logic             mute_rd,
  output logic             refill_req,
  output quad_t            refill_quad,
  output logic             underrun,
  output logic             overrun,
  output logic [CNT_W-1:0] ovr_count
);
  logic quiet;

  assign mute_rd = quiet && (rq != OPPOSITE);

  always_ff @(posedge clk) begin
    if (!rst_n || flush)                quiet <= 1'b1;
    else if (rd_go && rq == OPPOSITE)   quiet <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      refill_req  <= 1'b0;
      refill_quad <= '0;
      underrun    <= 1'b0;
    end else begin
      refill_req <= rd_go && last_in_quad;
      if (rd_go && last_in_quad) refill_quad <= rq;
      underrun <= starve;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun   <= 1'b0;
      ovr_count <= '0;
    end else begin
      overrun <= refused;
      if (refused && !(&ovr_count)) ovr_count <= ovr_count + 1'b1;
    end
  end
endmodule

// File: rtl/quad_ring_buf.sv
module quad_ring_buf
  import qring_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  input  logic             tick,
  output logic [DW-1:0]    smp_out,
  output logic             underrun,
  output logic             refill_req,
  output logic [1:0]       refill_quad,
  output logic             overrun,
  output logic [CNT_W-1:0] ovr_count,
  output logic             spaced_ok
);
  logic          wr_go, rd_go, starve, last_in_quad, mute_rd, refused;
  logic [AW-1:0] waddr, raddr;
  quad_t         rq, rf_q;

  assign refused     = wr_valid && !wr_ready && !flush;
  assign refill_quad = rf_q;

  qring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid), .tick(tick),
    .wr_ready(wr_ready), .wr_go(wr_go), .rd_go(rd_go), .starve(starve),
    .waddr(waddr), .raddr(raddr), .rq(rq), .last_in_quad(last_in_quad),
    .spaced_ok(spaced_ok)
  );

  qring_watch #(.CNT_W(CNT_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_go(rd_go), .starve(starve),
    .last_in_quad(last_in_quad), .rq(rq), .refused(refused), .mute_rd(mute_rd),
    .refill_req(refill_req), .refill_quad(rf_q), .underrun(underrun),
    .overrun(overrun), .ovr_count(ovr_count)
  );

  qring_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush), .we(wr_go), .waddr(waddr),
    .wdata(wr_data), .re(rd_go), .mute(mute_rd), .raddr(raddr), .q(smp_out)
  );
endmodule

// File: rtl/quad_ring_buf_chk.sv
module quad_ring_buf_chk #(
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             tick,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [DW-1:0]    smp_out,
  input logic             underrun,
  input logic             refill_req,
  input logic             overrun,
  input logic [CNT_W-1:0] ovr_count,
  input logic             spaced_ok
);
  // R1
  flush_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> spaced_ok);
  // R3
  refused_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !flush) |=> overrun);
  // R3
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ovr_count >= $past(ovr_count));
  // R5
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(tick) && !$past(flush));
  // R6
  refill_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |=> !refill_req);
  // R6
  refill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> $past(tick) && !underrun);
  // R8
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !wr_ready);
  // R9
  output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flush) |=> $stable(smp_out));
endmodule

bind quad_ring_buf quad_ring_buf_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .tick(tick), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .smp_out(smp_out), .underrun(underrun),
  .refill_req(refill_req), .overrun(overrun), .ovr_count(ovr_count),
  .spaced_ok(spaced_ok)
);

// File: tb/tb_quad_ring_buf.sv
module tb_quad_ring_buf;
  localparam int DEPTH = 16;
  localparam int Q     = DEPTH / 4;
  localparam int DW    = 16;
  localparam int CW    = 8;

  logic          clk = 1'b0, rst_n = 1'b0, flush = 1'b0, wr_valid = 1'b0, tick = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, underrun, refill_req, overrun, spaced_ok;
  logic [DW-1:0] smp_out;
  logic [1:0]    refill_quad;
  logic [CW-1:0] ovr_count;

  quad_ring_buf #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .tick(tick), .smp_out(smp_out),
    .underrun(underrun), .refill_req(refill_req), .refill_quad(refill_quad),
    .overrun(overrun), .ovr_count(ovr_count), .spaced_ok(spaced_ok)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [DW-1:0] d;
    bit un;
    bit rf;
    int rq;
    bit ok;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] data_q[$];
  int            m_rd, m_wr, m_ovr;
  logic [DW-1:0] last;
  int            vecs = 0, errs = 0;
  bit            tick_d = 1'b0;

  always @(posedge clk) tick_d <= tick;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_spaced();
    return ((((m_wr / Q) - (m_rd / Q)) % 4) + 4) % 4 == 2;
  endfunction

  function automatic void model_restart();
    m_rd = 0;
    m_wr = 2 * Q;
    last = '0;
    data_q.delete();
    for (int i = 0; i < 2 * Q; i++) data_q.push_back('0);
  endfunction

  // monitor: pops one expected result per tick and compares
  always @(negedge clk) begin : mon
    exp_t e;
    if (tick_d && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      if (e.un) begin
        chk("R5", "underrun", underrun, 1);
        chk("R5", "held smp_out", smp_out, e.d);
      end else begin
        chk("R5", "underrun", underrun, 0);
        chk("R4", "smp_out", smp_out, e.d);
      end
      chk("R6", "refill_req", refill_req, e.rf);
      if (e.rf) chk("R6", "refill_quad", refill_quad, e.rq);
      chk("R7", "spaced_ok", spaced_ok, e.ok);
    end
  end

  task automatic do_tick();
    exp_t e;
    @(negedge clk);
    e.rf = 1'b0;
    e.rq = 0;
    if (data_q.size() > 0) begin
      e.d  = data_q.pop_front();
      e.un = 1'b0;
      e.rf = (m_rd % Q) == Q - 1;
      e.rq = (m_rd / Q) % 4;
      m_rd++;
      last = e.d;
    end else begin
      e.d  = last;
      e.un = 1'b1;
    end
    e.ok = model_spaced();
    exp_q.push_back(e);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    bit rdy;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    #1;
    rdy = !((((m_wr / Q) % 4) == ((m_rd / Q) % 4)) && (data_q.size() >= Q));
    chk("R2", "wr_ready", wr_ready, rdy);
    if (rdy) begin
      data_q.push_back(d);
      m_wr++;
    end else if (m_ovr < (1 << CW) - 1) begin
      m_ovr++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    chk("R3", "overrun", overrun, !rdy);
    chk("R3", "ovr_count", ovr_count, m_ovr);
  endtask

  task automatic do_flush(input bit with_write);
    @(negedge clk);
    flush    = 1'b1;
    wr_valid = with_write;
    wr_data  = 16'hBEEF;
    #1;
    chk("R8", "wr_ready during flush", wr_ready, 0);
    @(negedge clk);
    flush    = 1'b0;
    wr_valid = 1'b0;
    model_restart();
    #1;
    chk("R8", "smp_out cleared", smp_out, 0);
    chk("R8", "ovr_count kept", ovr_count, m_ovr);
    chk("R8", "no overrun on flush", overrun, 0);
    chk("R1", "spaced_ok after flush", spaced_ok, 1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    m_ovr = 0;
    model_restart();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "smp_out reset", smp_out, 0);
    chk("R1", "spaced_ok reset", spaced_ok, 1);
    chk("R1", "wr_ready reset", wr_ready, 1);
    chk("R6", "refill_req reset", refill_req, 0);
    chk("R5", "underrun reset", underrun, 0);
    chk("R3", "ovr_count reset", ovr_count, 0);

    // burst fill until the writer reaches the reader's quadrant (R2, R3)
    for (int i = 0; i < 8; i++) do_write(DW'(16'h1000 + i));
    do_write(16'hDEAD);
    do_write(16'hDEAD);
    // silent lead-in and first crossing (R1, R6)
    for (int i = 0; i < 4; i++) do_tick();
    for (int i = 0; i < 4; i++) do_write(DW'(16'h2000 + i));
    do_write(16'hDEAD);
    // play everything out, then run dry (R4, R5, R9)
    for (int i = 0; i < 18; i++) do_tick();
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "smp_out idle hold", smp_out, last);

    // fine interleave around the reader's quadrant
    for (int i = 0; i < 24; i++) begin
      do_write(DW'(i * 37 + 5));
      if (i % 2 == 1) do_tick();
    end
    for (int i = 0; i < 6; i++) do_tick();

    // flush mid-stream with a write offered at the same edge (R8, R1)
    do_flush(1'b1);
    for (int i = 0; i < 6; i++) do_write(DW'(16'h3000 + i));
    for (int i = 0; i < 16; i++) do_tick();

    // plain flush, then a long burst and drain
    do_flush(1'b0);
    for (int i = 0; i < 12; i++) do_write(DW'(16'h4000 + 3 * i));
    for (int i = 0; i < 24; i++) do_tick();

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule